// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Port

This block is a full-duplex serial port using asynchronous NRZ framing. A small register port lets a host set the character format and the bit rate, write characters for transmission and read received ones. Each direction has a one-character holding register in front of its shift register. The host can therefore queue the next character while the current one is on the line, and a received character waits in the holding register while the next one is being shifted in.

The transmitter and the receiver each have an enable and an interrupt enable of their own, so either one can run alone or both can run at once. The receiver oversamples the line at eight times the bit rate and decides each bit by majority vote. It reports parity errors, framing errors, overruns and breaks through sticky status flags. The host clears these flags by writing ones to them.

Register map (addr): 0 = control, 1 = divisor, 2 = transmit data (write), 3 = receive data (read), 4 = status. Control bits: [0] transmit enable, [1] receive enable, [2] transmit interrupt enable, [3] receive interrupt enable, [5:4] data length minus five, [6] parity enable, [7] odd parity (0 = even), [8] two stop bits. Status bits: [0] transmit holding empty, [1] transmitter idle, [2] receive data ready, [3] parity error, [4] framing error, [5] overrun, [6] break. Read data appears on `rdata` one clock after `rd_en`.

Top module: `dbuf_uart`

## Requirements
- R1: After reset `tx` is high, both interrupts are low and status reads 0x0003 (transmit holding empty, transmitter idle).
- R2: A transmitted character is a low start bit, 5 to 8 data bits LSB first, an optional parity bit (even or odd over the data bits) and one or two high stop bits; the line idles high.
- R3: Every bit lasts 8*(DIV+1) clocks, where DIV is the 16-bit divisor register.
- R4: A write to transmit data fills the holding register only when it is empty. The holding register empties when its character moves to the shift register, so a second character can be queued during a transmission and follows it. A write while the holding register is full is ignored.
- R5: While transmit enable is 0 no new character leaves the holding register and `tx` stays high.
- R6: The receiver decodes characters of any format in R2, places the data (zero-extended) in receive data and sets data ready. Reading receive data clears data ready.
- R7: A received parity bit that does not match the configured parity sets the parity error flag.
- R8: A low first stop bit sets the framing error flag; the data is still delivered.
- R9: A character that completes while data ready is set sets the overrun flag and is discarded; the held character is kept.
- R10: The line held low for longer than one whole frame (start, data, parity and stop bits) sets the break flag. A shorter low does not.
- R11: While receive enable is 0 incoming characters are ignored.
- R12: `tx_irq` is high when transmit enable, transmit interrupt enable and transmit holding empty are all set. `rx_irq` is high when receive enable and receive interrupt enable are set and data ready or break is set.
- R13: Writing the status register clears each error flag (bits 3 to 6) whose bit is written 1 and leaves the others unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid one clock after rd_en |
| rx | input | 1 | Serial receive line |
| tx | output | 1 | Serial transmit line |
| tx_irq | output | 1 | Transmit ready interrupt |
| rx_irq | output | 1 | Receive interrupt |

## Verification
Both directions are tried with random data under random formats (all four lengths, parity off, even and odd, one or two stop bits) and random divisors. Because the bench samples each transmitted bit at its nominal centre, a wrong length, bit order, parity sense or bit period shows up as bad data. On the receive side, random characters with and without a corrupted parity bit separate correct parity checking from a checker that always or never flags. Directed patterns cover the remaining cases: a back-to-back queue with a third write while full, a disabled transmitter, a bad stop bit on an all-ones character (framing error but no break), two unread characters (overrun), a long low line (break), a disabled receiver and simultaneous traffic in both directions.

// File: rtl/dbu_pkg.sv
package dbu_pkg;
  localparam int ADDR_W = 3;
  localparam int OS_RATE = 8;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_DIV  = 3'd1;
  localparam logic [ADDR_W-1:0] A_TXD  = 3'd2;
  localparam logic [ADDR_W-1:0] A_RXD  = 3'd3;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd4;

  // character format, mapped onto control bits [8:4]
  typedef struct packed {
    logic       two_stop;
    logic       par_odd;
    logic       par_en;
    logic [1:0] len;
  } fmt_t;

  function automatic logic [3:0] fmt_bits(fmt_t f);
    return 4'(f.len) + 4'd5;
  endfunction
endpackage

// File: rtl/dbu_baud.sv
module dbu_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= div) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/dbu_tx.sv
module dbu_tx #(
  parameter int OS = 8,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          en,
  input  dbu_pkg::fmt_t fmt,
  input  logic          load_valid,
  input  logic [CW-1:0] load_data,
  output logic          load_ack,
  output logic          tx,
  output logic          busy
);
  localparam int SW = $clog2(OS);

  typedef enum logic [2:0] {T_IDLE, T_START, T_DATA, T_PAR, T_STOP} tst_t;

  tst_t          st;
  logic [SW-1:0] sub;
  logic [3:0]    bitn;
  logic [CW-1:0] sh;
  logic          pbit;
  logic [3:0]    nb;
  logic [CW-1:0] mask;
  logic          last_sub;

  assign nb       = dbu_pkg::fmt_bits(fmt);
  assign mask     = ~({CW{1'b1}} << nb);
  assign last_sub = (sub == SW'(OS - 1));
  assign busy     = (st != T_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= T_IDLE;
      sub      <= '0;
      bitn     <= '0;
      sh       <= '0;
      pbit     <= 1'b0;
      tx       <= 1'b1;
      load_ack <= 1'b0;
    end else begin
      load_ack <= 1'b0;
      if (tick) begin
        if (st == T_IDLE) begin
          if (en && load_valid) begin
            sh       <= load_data;
            pbit     <= (^(load_data & mask)) ^ fmt.par_odd;
            load_ack <= 1'b1;
            tx       <= 1'b0;
            sub      <= '0;
            st       <= T_START;
          end
        end else if (!last_sub) begin
          sub <= sub + 1'b1;
        end else begin
          sub <= '0;
          unique case (st)
            T_START: begin
              st   <= T_DATA;
              bitn <= '0;
              tx   <= sh[0];
              sh   <= sh >> 1;
            end
            T_DATA: begin
              if (bitn == nb - 4'd1) begin
                bitn <= '0;
                if (fmt.par_en) begin
                  st <= T_PAR;
                  tx <= pbit;
                end else begin
                  st <= T_STOP;
                  tx <= 1'b1;
                end
              end else begin
                bitn <= bitn + 4'd1;
                tx   <= sh[0];
                sh   <= sh >> 1;
              end
            end
            T_PAR: begin
              st <= T_STOP;
              tx <= 1'b1;
            end
            default: begin
              if (fmt.two_stop && bitn == 4'd0) begin
                bitn <= 4'd1;
              end else begin
                bitn <= '0;
                st   <= T_IDLE;
              end
            end
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/dbu_rx.sv
module dbu_rx #(
  parameter int OS = 8,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          en,
  input  dbu_pkg::fmt_t fmt,
  input  logic          rx,
  output logic          done,
  output logic [CW-1:0] data,
  output logic          par_err,
  output logic          frm_err,
  output logic          brk
);
  localparam int SW  = $clog2(OS);
  localparam int IW  = $clog2(CW);
  localparam int MID = OS / 2;
  localparam int BW  = $clog2(OS * (CW + 4) + 2);

  typedef enum logic [2:0] {R_IDLE, R_START, R_DATA, R_PAR, R_STOP} rst_t;

  rst_t          st;
  logic          rx_m, rx_s;
  logic [SW-1:0] sub;
  logic [3:0]    bitn;
  logic [CW-1:0] sh;
  logic [2:0]    smp;
  logic          armed, perr;
  logic          vote, last_sub;
  logic [3:0]    nb, frame_bits;
  logic [BW-1:0] frame_ticks, lcnt;
  logic          fired;

  assign nb          = dbu_pkg::fmt_bits(fmt);
  assign frame_bits  = 4'd2 + nb + {3'b0, fmt.par_en} + {3'b0, fmt.two_stop};
  assign frame_ticks = BW'(OS) * BW'(frame_bits);
  assign vote        = (smp[0] & smp[1]) | (smp[0] & smp[2]) | (smp[1] & smp[2]);
  assign last_sub    = (sub == SW'(OS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_m    <= 1'b1;
      rx_s    <= 1'b1;
      st      <= R_IDLE;
      sub     <= '0;
      bitn    <= '0;
      sh      <= '0;
      smp     <= '0;
      armed   <= 1'b0;
      perr    <= 1'b0;
      done    <= 1'b0;
      data    <= '0;
      par_err <= 1'b0;
      frm_err <= 1'b0;
    end else begin
      rx_m <= rx;
      rx_s <= rx_m;
      done <= 1'b0;
      if (tick) begin
        if (st == R_IDLE) begin
          if (rx_s) begin
            armed <= 1'b1;
          end else if (armed && en) begin
            armed <= 1'b0;
            st    <= R_START;
            sub   <= SW'(1);
            sh    <= '0;
            perr  <= 1'b0;
          end
        end else begin
          if (sub == SW'(MID - 1)) smp[0] <= rx_s;
          if (sub == SW'(MID))     smp[1] <= rx_s;
          if (sub == SW'(MID + 1)) smp[2] <= rx_s;
          if (!last_sub) begin
            sub <= sub + 1'b1;
          end else begin
            sub <= '0;
            unique case (st)
              R_START: begin
                bitn <= '0;
                if (vote) st <= R_IDLE;
                else      st <= R_DATA;
              end
              R_DATA: begin
                sh[bitn[IW-1:0]] <= vote;
                if (bitn == nb - 4'd1) begin
                  bitn <= '0;
                  st   <= fmt.par_en ? R_PAR : R_STOP;
                end else begin
                  bitn <= bitn + 4'd1;
                end
              end
              R_PAR: begin
                perr <= ((^sh) ^ vote) != fmt.par_odd;
                st   <= R_STOP;
              end
              default: begin
                done    <= 1'b1;
                data    <= sh;
                frm_err <= ~vote;
                par_err <= perr & fmt.par_en;
                armed   <= vote;
                st      <= R_IDLE;
              end
            endcase
          end
        end
      end
    end
  end

  // break: count oversample ticks of continuous low line
  always_ff @(posedge clk) begin
    if (rst) begin
      lcnt  <= '0;
      fired <= 1'b0;
      brk   <= 1'b0;
    end else begin
      brk <= 1'b0;
      if (tick) begin
        if (rx_s || !en) begin
          lcnt  <= '0;
          fired <= 1'b0;
        end else if (!fired) begin
          if (lcnt >= frame_ticks) begin
            brk   <= 1'b1;
            fired <= 1'b1;
          end else begin
            lcnt <= lcnt + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/dbuf_uart.sv
module dbuf_uart #(
  parameter int DIV_W = 16,
  parameter int REG_W = 16,
  parameter int CW    = 8,
  parameter int OS    = dbu_pkg::OS_RATE
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic                       rd_en,
  input  logic [dbu_pkg::ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]           wdata,
  output logic [REG_W-1:0]           rdata,
  input  logic                       rx,
  output logic                       tx,
  output logic                       tx_irq,
  output logic                       rx_irq
);
  import dbu_pkg::*;

  logic [REG_W-1:0] ctrl;
  logic [DIV_W-1:0] div;
  logic [CW-1:0]    tx_hold, rx_hold;
  logic             tx_hold_full, rx_ready;
  logic             pe_f, fe_f, oe_f, be_f;
  logic             tick, tx_ack, tx_busy;
  logic             rx_done, rx_perr, rx_ferr, rx_brk;
  logic [CW-1:0]    rx_data;
  logic             c_txen, c_rxen, c_txie, c_rxie;
  fmt_t             fmt;
  logic [6:0]       status;

  assign c_txen = ctrl[0];
  assign c_rxen = ctrl[1];
  assign c_txie = ctrl[2];
  assign c_rxie = ctrl[3];
  assign fmt    = fmt_t'(ctrl[8:4]);
  assign status = {be_f, oe_f, fe_f, pe_f, rx_ready, ~tx_busy, ~tx_hold_full};

  dbu_baud #(.DIV_W(DIV_W)) u_baud (
    .clk (clk), .rst (rst), .div (div), .tick (tick)
  );

  dbu_tx #(.OS(OS), .CW(CW)) u_tx (
    .clk (clk), .rst (rst), .tick (tick), .en (c_txen), .fmt (fmt),
    .load_valid (tx_hold_full), .load_data (tx_hold), .load_ack (tx_ack),
    .tx (tx), .busy (tx_busy)
  );

  dbu_rx #(.OS(OS), .CW(CW)) u_rx (
    .clk (clk), .rst (rst), .tick (tick), .en (c_rxen), .fmt (fmt), .rx (rx),
    .done (rx_done), .data (rx_data), .par_err (rx_perr), .frm_err (rx_ferr),
    .brk (rx_brk)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl         <= '0;
      div          <= '0;
      tx_hold      <= '0;
      tx_hold_full <= 1'b0;
      rx_hold      <= '0;
      rx_ready     <= 1'b0;
      pe_f         <= 1'b0;
      fe_f         <= 1'b0;
      oe_f         <= 1'b0;
      be_f         <= 1'b0;
      rdata        <= '0;
      tx_irq       <= 1'b0;
      rx_irq       <= 1'b0;
    end else begin
      if (wr_en) begin
        unique case (addr)
          A_CTRL: ctrl <= wdata;
          A_DIV:  div  <= wdata[DIV_W-1:0];
          A_TXD: begin
            if (!tx_hold_full) begin
              tx_hold      <= wdata[CW-1:0];
              tx_hold_full <= 1'b1;
            end
          end
          A_STAT: begin
            if (wdata[3]) pe_f <= 1'b0;
            if (wdata[4]) fe_f <= 1'b0;
            if (wdata[5]) oe_f <= 1'b0;
            if (wdata[6]) be_f <= 1'b0;
          end
          default: ;
        endcase
      end
      if (tx_ack) tx_hold_full <= 1'b0;

      if (rd_en) begin
        unique case (addr)
          A_CTRL: rdata <= ctrl;
          A_DIV:  rdata <= REG_W'(div);
          A_RXD: begin
            rdata    <= REG_W'(rx_hold);
            rx_ready <= 1'b0;
          end
          A_STAT: rdata <= REG_W'(status);
          default: rdata <= '0;
        endcase
      end

      if (rx_done) begin
        if (rx_ready) begin
          oe_f <= 1'b1;
        end else begin
          rx_hold  <= rx_data;
          rx_ready <= 1'b1;
          if (rx_perr) pe_f <= 1'b1;
          if (rx_ferr) fe_f <= 1'b1;
        end
      end
      if (rx_brk) be_f <= 1'b1;

      tx_irq <= c_txen & c_txie & ~tx_hold_full;
      rx_irq <= c_rxen & c_rxie & (rx_ready | be_f);
    end
  end
endmodule

// File: rtl/dbu_chk.sv
module dbu_chk #(
  parameter int CW = 8
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       wr_en,
  input logic [dbu_pkg::ADDR_W-1:0] addr,
  input logic                       tx,
  input logic                       tx_irq,
  input logic                       c_txen,
  input logic                       c_txie,
  input logic                       tx_hold_full,
  input logic                       tx_busy,
  input logic                       rx_ready,
  input logic                       oe_f,
  input logic [CW-1:0]              rx_hold
);
  // R2
  line_idle_high_chk: assert property (@(posedge clk) disable iff (rst)
    !tx_busy |-> tx);

  // R4
  hold_fill_by_write_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_hold_full) |-> $past(wr_en && addr == dbu_pkg::A_TXD));

  // R5
  start_when_enabled_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_busy) |-> $past(c_txen));

  // R9
  overrun_needs_ready_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(oe_f) |-> $past(rx_ready));

  // R6
  held_char_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_ready && $past(rx_ready)) |-> $stable(rx_hold));

  // R12
  tx_irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    tx_irq |-> $past(c_txen && c_txie && !tx_hold_full));
endmodule

bind dbuf_uart dbu_chk #(.CW(CW)) i_dbu_chk (
  .clk (clk), .rst (rst), .wr_en (wr_en), .addr (addr), .tx (tx),
  .tx_irq (tx_irq), .c_txen (c_txen), .c_txie (c_txie),
  .tx_hold_full (tx_hold_full), .tx_busy (tx_busy), .rx_ready (rx_ready),
  .oe_f (oe_f), .rx_hold (rx_hold)
);

// File: tb/test_dbuf_uart.sv
module test_dbuf_uart;
  import dbu_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        rx = 1'b1;
  logic        tx, tx_irq, rx_irq;

  always #2 clk = ~clk;

  dbuf_uart i_dbuf_uart (
    .clk (clk), .rst (rst), .wr_en (wr_en), .rd_en (rd_en), .addr (addr),
    .wdata (wdata), .rdata (rdata), .rx (rx), .tx (tx), .tx_irq (tx_irq),
    .rx_irq (rx_irq)
  );

  int checks = 0, errors = 0;
  bit finished = 0;
  int bitclk = 8;
  int c_nb = 8;
  bit c_pen = 0, c_podd = 0, c_two = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic setcfg(input int dv, input bit txen, input bit rxen, input bit txie,
                        input bit rxie, input int len, input bit pen, input bit podd,
                        input bit two);
    wr(A_DIV, 16'(dv));
    wr(A_CTRL, {7'd0, two, podd, pen, 2'(len), rxie, txie, rxen, txen});
    bitclk = 8 * (dv + 1);
    c_nb = len + 5; c_pen = pen; c_podd = podd; c_two = two;
  endtask

  function automatic logic [7:0] msk(input logic [7:0] d);
    return d & (8'hFF >> (8 - c_nb));
  endfunction

  function automatic logic parity_of(input logic [7:0] d);
    return (^msk(d)) ^ c_podd;
  endfunction

  task automatic wait_bits(input int n);
    repeat (n * bitclk) @(negedge clk);
  endtask

  // sample each bit at its nominal centre
  task automatic capture(output logic [7:0] d, output bit ok);
    int t = 0;
    while (tx !== 1'b0 && t < 20000) begin @(negedge clk); t++; end
    repeat (bitclk / 2) @(negedge clk);
    ok = (tx == 1'b0);
    d = '0;
    for (int i = 0; i < c_nb; i++) begin
      repeat (bitclk) @(negedge clk);
      d[i] = tx;
    end
    if (c_pen) begin
      repeat (bitclk) @(negedge clk);
      ok &= (tx == parity_of(d));
    end
    repeat (bitclk) @(negedge clk);
    ok &= (tx == 1'b1);
    if (c_two) begin
      repeat (bitclk) @(negedge clk);
      ok &= (tx == 1'b1);
    end
  endtask

  task automatic drive(input logic [7:0] d, input bit badpar, input bit badstop);
    @(negedge clk);
    rx = 1'b0; repeat (bitclk) @(negedge clk);
    for (int i = 0; i < c_nb; i++) begin
      rx = d[i]; repeat (bitclk) @(negedge clk);
    end
    if (c_pen) begin
      rx = parity_of(d) ^ badpar; repeat (bitclk) @(negedge clk);
    end
    rx = ~badstop; repeat (bitclk) @(negedge clk);
    rx = 1'b1;
    if (c_two) repeat (bitclk) @(negedge clk);
    repeat (bitclk) @(negedge clk);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: run hung actual=hung expected=done");
      report();
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    logic [7:0]  got, a, b, c;
    bit          ok, seen;
    void'($urandom(32'd1357));

    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(tx == 1'b1, "R1 tx idle", int'(tx), 1);
    check({tx_irq, rx_irq} == 2'b00, "R1 irqs", int'({tx_irq, rx_irq}), 0);
    rd(A_STAT, r);
    check(r == 16'h0003, "R1 status", int'(r), 3);

    // R2 R3 directed 8N1
    setcfg(1, 1, 0, 0, 0, 3, 0, 0, 0);
    fork
      capture(got, ok);
      wr(A_TXD, 16'h00A5);
    join
    check(ok && got == 8'hA5, "R2 R3 8N1 char", int'(got), 'hA5);

    // R2 R3 random formats and divisors
    for (int i = 0; i < 14; i++) begin
      int dv = $urandom_range(0, 3);
      int ln = $urandom_range(0, 3);
      bit pe = 1'($urandom_range(0, 1));
      bit po = 1'($urandom_range(0, 1));
      bit tw = 1'($urandom_range(0, 1));
      logic [7:0] d = 8'($urandom);
      setcfg(dv, 1, 0, 0, 0, ln, pe, po, tw);
      fork
        capture(got, ok);
        wr(A_TXD, {8'd0, d});
      join
      check(ok, "R2 framing/parity/stop", int'(ok), 1);
      check(got == msk(d), "R3 data at bit centres", int'(got), int'(msk(d)));
    end

    // R4 double buffering, write while full ignored
    setcfg(1, 1, 0, 0, 0, 3, 0, 0, 0);
    fork
      begin
        capture(a, ok);
        capture(b, seen);
      end
      begin
        wr(A_TXD, 16'h0031);
        repeat (10) @(negedge clk);
        rd(A_STAT, r);
        check(r[1:0] == 2'b01, "R4 holding empty while shifting", int'(r[1:0]), 1);
        wr(A_TXD, 16'h00C2);
        wr(A_TXD, 16'h0077);
        rd(A_STAT, r);
        check(r[0] == 1'b0, "R4 holding full", int'(r[0]), 0);
      end
    join
    check(ok && a == 8'h31, "R4 first char", int'(a), 'h31);
    check(seen && b == 8'hC2, "R4 queued char", int'(b), 'hC2);
    seen = 0;
    repeat (3 * 10 * bitclk) begin @(negedge clk); if (tx == 1'b0) seen = 1; end
    check(!seen, "R4 write while full dropped", int'(seen), 0);

    // R5 transmitter disabled, R12 tx interrupt
    setcfg(1, 0, 0, 1, 0, 3, 0, 0, 0);
    wr(A_TXD, 16'h005A);
    seen = 0;
    repeat (2 * 10 * bitclk) begin @(negedge clk); if (tx == 1'b0) seen = 1; end
    check(!seen, "R5 no start while disabled", int'(seen), 0);
    rd(A_STAT, r);
    check(r[0] == 1'b0, "R5 char still held", int'(r[0]), 0);
    check(tx_irq == 1'b0, "R12 tx_irq off when disabled", int'(tx_irq), 0);
    fork
      capture(got, ok);
      wr(A_CTRL, 16'h0035);
    join
    check(ok && got == 8'h5A, "R5 sent after enable", int'(got), 'h5A);
    repeat (3) @(negedge clk);
    check(tx_irq == 1'b1, "R12 tx_irq when empty", int'(tx_irq), 1);

    // R6 R7 R12 random receive
    for (int i = 0; i < 14; i++) begin
      int dv = $urandom_range(0, 3);
      int ln = $urandom_range(0, 3);
      bit pe = 1'($urandom_range(0, 1));
      bit po = 1'($urandom_range(0, 1));
      bit tw = 1'($urandom_range(0, 1));
      bit bp = pe & 1'($urandom_range(0, 1));
      logic [7:0] d = 8'($urandom);
      setcfg(dv, 0, 1, 0, 1, ln, pe, po, tw);
      drive(d, bp, 0);
      check(rx_irq == 1'b1, "R12 rx_irq on ready", int'(rx_irq), 1);
      rd(A_STAT, r);
      check(r[2] == 1'b1, "R6 data ready", int'(r[2]), 1);
      check(r[3] == bp, "R7 parity flag", int'(r[3]), int'(bp));
      rd(A_RXD, r);
      check(r == {8'd0, msk(d)}, "R6 received data", int'(r), int'(msk(d)));
      wr(A_STAT, 16'h0078);
      rd(A_STAT, r);
      check(r[6:2] == 5'd0, "R6 R13 ready and flags clear", int'(r[6:2]), 0);
      check(rx_irq == 1'b0, "R12 rx_irq after read", int'(rx_irq), 0);
    end

    // R8 framing error, R10 short low is not a break
    setcfg(1, 0, 1, 0, 0, 3, 0, 0, 0);
    drive(8'hFF, 0, 1);
    rd(A_STAT, r);
    check(r[4] == 1'b1, "R8 framing flag", int'(r[4]), 1);
    check(r[6] == 1'b0, "R10 no break on short low", int'(r[6]), 0);
    rd(A_RXD, r);
    check(r == 16'h00FF, "R8 data delivered", int'(r), 'hFF);

    // R9 overrun, R13 selective clear
    drive(8'h3C, 0, 0);
    drive(8'hE1, 0, 0);
    rd(A_STAT, r);
    check(r[5] == 1'b1, "R9 overrun flag", int'(r[5]), 1);
    wr(A_STAT, 16'h0020);
    rd(A_STAT, r);
    check(r[5:4] == 2'b01, "R13 clear overrun only", int'(r[5:4]), 1);
    rd(A_RXD, r);
    check(r == 16'h003C, "R9 first char kept", int'(r), 'h3C);
    wr(A_STAT, 16'h0078);

    // R10 break
    @(negedge clk); rx = 1'b0;
    wait_bits(14);
    rx = 1'b1;
    wait_bits(2);
    rd(A_STAT, r);
    check(r[6] == 1'b1, "R10 break flag", int'(r[6]), 1);
    rd(A_RXD, r);
    wr(A_STAT, 16'h0078);
    rd(A_STAT, r);
    check(r[6:2] == 5'd0, "R13 all cleared", int'(r[6:2]), 0);

    // R11 receiver disabled
    setcfg(1, 0, 0, 0, 1, 3, 0, 0, 0);
    drive(8'h96, 0, 0);
    rd(A_STAT, r);
    check(r[2] == 1'b0, "R11 ignored while disabled", int'(r[2]), 0);
    check(rx_irq == 1'b0, "R11 no rx_irq", int'(rx_irq), 0);

    // R2 R6 full duplex
    setcfg(2, 1, 1, 0, 0, 2, 1, 1, 0);
    c = 8'($urandom);
    fork
      capture(got, ok);
      wr(A_TXD, 16'h004B);
      drive(c, 0, 0);
    join
    check(ok && got == msk(8'h4B), "R2 duplex tx", int'(got), int'(msk(8'h4B)));
    rd(A_RXD, r);
    check(r == {8'd0, msk(c)}, "R6 duplex rx", int'(r), int'(msk(c)));

    finished = 1;
    report();
    $finish;
  end
endmodule